// File: doc/BRIEF.md
# Serial Interface Interrupt Request Logic

This block keeps the interrupt enables and the event flags of a byte-oriented serial controller. From them it drives three level-sensitive request lines: transmit buffer empty, transmit end, and receive buffer full. A fourth line reports an overrun error. The shift engine does not live here. It reports what happens through single-cycle strobes:
- a byte was loaded into the transmit buffer;
- the transmit buffer was handed to the shifter;
- the ninth bit clock rose;
- a received byte moved into the receive buffer;
- the receive buffer was read.

Software reaches the block through a small register port. Select 0 is the 8-bit enable register. Select 1 is the status register. A status flag is cleared by first reading it as 1 and then writing 0 to its bit. An overrun is detected inside the block when a new byte arrives while the receive buffer is still full. It raises the error line only when the mode input selects the clocked synchronous format.

Top module: `sif_irq_ctrl`

## Requirements
- R1: Enable register (reg_sel=0): bit 7 enables the transmit-empty request, bit 6 enables the transmit-end request, and bit 5 enables the receive request. All three reset to 0 and can be written and read back. Bits 4..0 read as 0 and ignore writes.
- R2: Status register (reg_sel=1): bit 7 is tx_empty, bit 6 is tx_end, bit 5 is rx_full and bit 4 is overrun. Bits 3..0 read as 0. All flags reset to 0.
- R3: tx_empty is set by txbuf_empty_evt and cleared by txbuf_load.
- R4: tx_end is set by bit9_rise only while tx_empty is 1. A bit9_rise while tx_empty is 0 leaves tx_end at 0.
- R5: rx_full is set by rx_xfer and cleared by rxbuf_read.
- R6: overrun is set by an rx_xfer that arrives while rx_full is 1. It then holds until software clears it.
- R7: Writing 0 to a status bit clears that flag only if an earlier status read returned the bit as 1 and no status write has happened since that read. Writing 0 without such a read leaves the flag set. Writing 1 leaves the flag set.
- R8: A hardware set event in the same cycle as a software or hardware clear leaves the flag at 1.
- R9: irq_txe is 1 exactly when tx_empty and enable bit 7 were both 1 in the previous cycle.
- R10: irq_tend follows tx_end AND enable bit 6. Clearing either of them withdraws the request.
- R11: irq_rxf follows rx_full AND enable bit 5. Clearing either of them withdraws the request.
- R12: irq_err follows overrun AND enable bit 5 AND sync_mode. While sync_mode is 0 the line stays low.
- R13: All four request outputs are registered. Each changes one clock after the flag or enable change that causes it, and each is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the status register |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| txbuf_load | input | 1 | Transmit buffer written |
| txbuf_empty_evt | input | 1 | Transmit buffer moved to the shifter |
| bit9_rise | input | 1 | Rising edge of the ninth bit clock |
| rx_xfer | input | 1 | Received byte moved into the receive buffer |
| rxbuf_read | input | 1 | Receive buffer read |
| sync_mode | input | 1 | Clocked synchronous format selected |
| irq_txe | output | 1 | Transmit buffer empty request |
| irq_tend | output | 1 | Transmit end request |
| irq_rxf | output | 1 | Receive buffer full request |
| irq_err | output | 1 | Overrun error request |

## Verification
The hardest states to reach are the flag combinations that a real transfer does not leave behind. Examples are tx_end set with tx_empty clear, and overrun set with rx_full already drained. The stimulus builds each of the sixteen flag patterns with a fixed strobe recipe. For tx_end it sets tx_empty, strobes the ninth clock, then reloads the buffer. For overrun it transfers two bytes, then reads the buffer. Every pattern is crossed with all eight enable settings and both modes. Each crossing is checked and then cleared through the read-then-write-0 path. Directed cases then force a hardware set and a clear into the same cycle.

// File: rtl/sif_irq_pkg.sv
// Package: shared widths, flag indices and enable-bit positions of the
// serial interface interrupt logic. Assumes an 8-bit register port.
package sif_irq_pkg;
    localparam int REG_W   = 8;
    localparam int N_FLAGS = 4;
    localparam int N_EN    = 3;
    // Flag vector indices; status byte places the vector in its top bits.
    localparam int F_TXE  = 3;
    localparam int F_TEND = 2;
    localparam int F_RXF  = 1;
    localparam int F_OVR  = 0;
    // Enable vector indices; enable byte places the vector in its top bits.
    localparam int E_TXE  = 2;
    localparam int E_TEND = 1;
    localparam int E_RX   = 0;
    localparam int STAT_LO_W = REG_W - N_FLAGS;
    localparam int EN_LO_W   = REG_W - N_EN;
endpackage

// File: rtl/sif_irq_en_reg.sv
// Module: enable register. Holds the three request enables in the top bits
// of the register byte. Assumes wr_en is a single-cycle write strobe.
module sif_irq_en_reg
    import sif_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [N_EN-1:0] wbits,
    output logic [N_EN-1:0] en_q
);
    // Capture written enables; reset clears all of them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= wbits;
    end
endmodule

// File: rtl/sif_irq_flags.sv
// Module: status flags with hardware set and clear, and a software clear
// that needs a prior read returning 1. Set wins over every clear.
// Assumes one status access per cycle at most of each kind.
module sif_irq_flags
    import sif_irq_pkg::*;
#(
    parameter int NF = N_FLAGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] hw_set,
    input  logic [NF-1:0] hw_clr,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic [NF-1:0] wbits,
    output logic [NF-1:0] flags_q
);
    logic [NF-1:0] armed_q;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic sw_clr;
        assign sw_clr = stat_wr & armed_q[i] & ~wbits[i];

        // Flag update: set beats hardware or software clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (hw_set[i])
                flags_q[i] <= 1'b1;
            else if (hw_clr[i] | sw_clr)
                flags_q[i] <= 1'b0;
        end

        // Arm the software clear when a read sees the flag at 1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                armed_q[i] <= 1'b0;
            else if (stat_wr)
                armed_q[i] <= 1'b0;
            else if (stat_rd & flags_q[i])
                armed_q[i] <= 1'b1;
            else if (!flags_q[i])
                armed_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sif_irq_req.sv
// Module: registered request lines. Each line is a flag gated by its
// enable; the error line is also gated by the synchronous mode.
module sif_irq_req
    import sif_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] flags,
    input  logic [N_EN-1:0]    en,
    input  logic               sync_mode,
    output logic               irq_txe,
    output logic               irq_tend,
    output logic               irq_rxf,
    output logic               irq_err
);
    // Register the gated levels so requests are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_txe  <= 1'b0;
            irq_tend <= 1'b0;
            irq_rxf  <= 1'b0;
            irq_err  <= 1'b0;
        end else begin
            irq_txe  <= flags[F_TXE]  & en[E_TXE];
            irq_tend <= flags[F_TEND] & en[E_TEND];
            irq_rxf  <= flags[F_RXF]  & en[E_RX];
            irq_err  <= flags[F_OVR]  & en[E_RX] & sync_mode;
        end
    end
endmodule

// File: rtl/sif_irq_ctrl.sv
// Module: top of the serial interface interrupt logic. Decodes the
// register port, derives flag set/clear events from core strobes and
// feeds the registered request stage. Assumes strobes are one cycle wide.
module sif_irq_ctrl
    import sif_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             txbuf_load,
    input  logic             txbuf_empty_evt,
    input  logic             bit9_rise,
    input  logic             rx_xfer,
    input  logic             rxbuf_read,
    input  logic             sync_mode,
    output logic             irq_txe,
    output logic             irq_tend,
    output logic             irq_rxf,
    output logic             irq_err
);
    logic [N_EN-1:0]    en_q;
    logic [N_FLAGS-1:0] flags_q;
    logic [N_FLAGS-1:0] hw_set;
    logic [N_FLAGS-1:0] hw_clr;
    logic               en_wr;
    logic               stat_wr;
    logic               stat_rd;
    logic               unused_wdata_lo;

    assign unused_wdata_lo = ^wdata[STAT_LO_W-1:0];

    // Register port decode.
    assign en_wr   = wr_en & ~reg_sel;
    assign stat_wr = wr_en &  reg_sel;
    assign stat_rd = rd_en &  reg_sel;

    // Hardware flag events from core strobes.
    always_comb begin
        hw_set         = '0;
        hw_clr         = '0;
        hw_set[F_TXE]  = txbuf_empty_evt;
        hw_set[F_TEND] = bit9_rise & flags_q[F_TXE];
        hw_set[F_RXF]  = rx_xfer;
        hw_set[F_OVR]  = rx_xfer & flags_q[F_RXF];
        hw_clr[F_TXE]  = txbuf_load;
        hw_clr[F_RXF]  = rxbuf_read;
    end

    // Read data multiplexer; unused low bits read as zero.
    always_comb begin
        if (reg_sel)
            rdata = {flags_q, {STAT_LO_W{1'b0}}};
        else
            rdata = {en_q, {EN_LO_W{1'b0}}};
    end

    sif_irq_en_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (en_wr),
        .wbits (wdata[REG_W-1 -: N_EN]),
        .en_q  (en_q)
    );

    sif_irq_flags #(.NF(N_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_set  (hw_set),
        .hw_clr  (hw_clr),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr),
        .wbits   (wdata[REG_W-1 -: N_FLAGS]),
        .flags_q (flags_q)
    );

    sif_irq_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags_q),
        .en        (en_q),
        .sync_mode (sync_mode),
        .irq_txe   (irq_txe),
        .irq_tend  (irq_tend),
        .irq_rxf   (irq_rxf),
        .irq_err   (irq_err)
    );
endmodule

// File: rtl/sif_irq_ctrl_chk.sv
// Module: property checker for sif_irq_ctrl, attached through bind.
// Observes core strobes, internal flags and request outputs.
module sif_irq_ctrl_chk
    import sif_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [N_FLAGS-1:0] flags,
    input logic               txbuf_empty_evt,
    input logic               bit9_rise,
    input logic               rx_xfer,
    input logic               stat_wr,
    input logic               sync_mode,
    input logic               irq_tend,
    input logic               irq_err
);
    // R3
    txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txbuf_empty_evt |=> flags[F_TXE]);
    // R4
    tend_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit9_rise && !flags[F_TXE] && !flags[F_TEND]) |=> !flags[F_TEND]);
    // R5
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_xfer |=> flags[F_RXF]);
    // R6
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[F_OVR] && !stat_wr) |=> flags[F_OVR]);
    // R10
    tend_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[F_TEND] |=> !irq_tend);
    // R12
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |=> !irq_err);
endmodule

bind sif_irq_ctrl sif_irq_ctrl_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .flags           (flags_q),
    .txbuf_empty_evt (txbuf_empty_evt),
    .bit9_rise       (bit9_rise),
    .rx_xfer         (rx_xfer),
    .stat_wr         (stat_wr),
    .sync_mode       (sync_mode),
    .irq_tend        (irq_tend),
    .irq_err         (irq_err)
);

// File: tb/sif_irq_ctrl_tb_top.sv
// Bench: sweeps every flag pattern against every enable setting and both
// modes, then runs directed corner cases. Expected values are arithmetic.
module sif_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_sel, wr_en, rd_en;
    logic [7:0] wdata, rdata;
    logic       txbuf_load, txbuf_empty_evt, bit9_rise, rx_xfer, rxbuf_read;
    logic       sync_mode;
    logic       irq_txe, irq_tend, irq_rxf, irq_err;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sif_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .txbuf_load(txbuf_load), .txbuf_empty_evt(txbuf_empty_evt),
        .bit9_rise(bit9_rise), .rx_xfer(rx_xfer), .rxbuf_read(rxbuf_read),
        .sync_mode(sync_mode), .irq_txe(irq_txe), .irq_tend(irq_tend),
        .irq_rxf(irq_rxf), .irq_err(irq_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel; rd_en = 1'b1;
        #1 d = rdata;
        tick();
        rd_en = 1'b0;
    endtask

    // mask bits: 4 load, 3 empty_evt, 2 bit9, 1 rx_xfer, 0 rxbuf_read
    task automatic strobe(input logic [4:0] m);
        {txbuf_load, txbuf_empty_evt, bit9_rise, rx_xfer, rxbuf_read} = m;
        tick();
        {txbuf_load, txbuf_empty_evt, bit9_rise, rx_xfer, rxbuf_read} = '0;
    endtask

    function automatic logic [7:0] irqs();
        return {4'b0, irq_txe, irq_tend, irq_rxf, irq_err};
    endfunction

    task automatic clear_all();
        logic [7:0] d;
        rd(1'b1, d);
        wr(1'b1, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; reg_sel = 0; wr_en = 0; rd_en = 0; wdata = 0;
        {txbuf_load, txbuf_empty_evt, bit9_rise, rx_xfer, rxbuf_read} = '0;
        sync_mode = 0;
        repeat (3) tick();
        check("R13 reset irqs", irqs(), 8'h00);
        rst_n = 1'b1;
        tick();
        rd(1'b0, d); check("R1 reset enable", d, 8'h00);
        rd(1'b1, d); check("R2 reset status", d, 8'h00);

        // Sweep: flag pattern x enables x mode.
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 8; e++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [3:0] pf;
                    logic [2:0] ev;
                    logic [7:0] exp_irq;
                    pf = 4'(p); ev = 3'(e);
                    if (pf[2]) begin
                        strobe(5'b01000); strobe(5'b00100);
                        if (!pf[3]) strobe(5'b10000);
                    end else if (pf[3]) strobe(5'b01000);
                    if (pf[0]) begin
                        strobe(5'b00010); strobe(5'b00010);
                        if (!pf[1]) strobe(5'b00001);
                    end else if (pf[1]) strobe(5'b00010);
                    sync_mode = s[0];
                    wr(1'b0, {ev, 5'b10101});
                    tick();
                    rd(1'b0, d); check("R1 enable readback", d, {ev, 5'b0});
                    rd(1'b1, d); check("R2 R3 R4 R5 R6 status", d, {pf, 4'b0});
                    exp_irq = {4'b0, pf[3] & ev[2], pf[2] & ev[1],
                               pf[1] & ev[0], pf[0] & ev[0] & s[0]};
                    check("R9 R10 R11 R12 irqs", irqs(), exp_irq);
                    clear_all();
                    rd(1'b1, d); check("R7 cleared", d, 8'h00);
                    check("R13 irqs after clear", irqs(), 8'h00);
                end
            end
        end

        // R4: ninth clock with transmit buffer not empty.
        strobe(5'b00100);
        rd(1'b1, d); check("R4 no tend without txe", d, 8'h00);

        // R13 latency and R7 write-0 without read.
        wr(1'b0, 8'hE0);
        sync_mode = 1'b1;
        strobe(5'b01000);
        check("R13 one-cycle latency", {7'b0, irq_txe}, 8'h00);
        tick();
        check("R9 irq_txe", {7'b0, irq_txe}, 8'h01);
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R7 no clear without read", d, 8'h80);
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R7 write 1 keeps, disarms", d, 8'h80);

        // R8: set and software clear in the same cycle.
        reg_sel = 1'b1; wdata = 8'h00; wr_en = 1'b1; txbuf_empty_evt = 1'b1;
        tick();
        wr_en = 1'b0; txbuf_empty_evt = 1'b0;
        rd(1'b1, d); check("R8 set beats sw clear", d, 8'h80);
        // R8: set and hardware clear in the same cycle.
        strobe(5'b11000);
        rd(1'b1, d); check("R8 set beats load", d, 8'h80);
        strobe(5'b00011);
        rd(1'b1, d); check("R8 rx set beats read", d, 8'hA0);

        // R10: transmit-end withdrawn by clearing the enable bit.
        strobe(5'b00100);
        tick();
        check("R10 tend raised", {7'b0, irq_tend}, 8'h01);
        wr(1'b0, 8'hA0);
        tick();
        check("R10 tend withdrawn by enable", {7'b0, irq_tend}, 8'h00);

        // R11: receive request withdrawn by reading the buffer.
        check("R11 rxf raised", {7'b0, irq_rxf}, 8'h01);
        strobe(5'b00001);
        tick();
        check("R11 rxf withdrawn by read", {7'b0, irq_rxf}, 8'h00);

        // R6/R12: overrun holds; error line follows mode.
        strobe(5'b00010); strobe(5'b00010);
        strobe(5'b00001);
        repeat (3) tick();
        rd(1'b1, d); check("R6 overrun holds", d, 8'hD0);
        check("R12 err in sync mode", {7'b0, irq_err}, 8'h01);
        sync_mode = 1'b0;
        tick();
        check("R12 err masked by mode", {7'b0, irq_err}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule